// File: doc/BRIEF.md
# ARP Request and Reply Engine

This block answers and issues address-resolution traffic for one station whose hardware address and IPv4 address are fixed by parameters. A receive parser hands it the decoded fields of each incoming ARP packet as a one-cycle strobe. A separate trigger asks it to resolve a single peer whose IPv4 address is also a parameter. The block builds each outgoing frame byte by byte for a GMII transmit path. A frame consists of the preamble, the start delimiter, the Ethernet header, the ARP body, zero padding up to the minimum frame size, and the CRC-32 frame check sequence.

A well-formed request that names the local IPv4 address schedules a reply to the asker. A well-formed reply addressed to the local IPv4 address stores the sender's hardware address as the resolved peer address. Any later such reply overwrites it. Both kinds of work are held as pending flags until the transmit serialiser is free. A reply always goes out ahead of a request.

Top module: `arp_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it, `gmii_tx_en` is 0, `peer_mac_valid` is 0 and `peer_mac` is zero.
- R2: A high `req_trigger` produces one request frame with these contents: destination address all ones, EtherType 0x0806, opcode 0x0001, sender address and IP equal to the local ones, target hardware address zero, and target IP equal to the peer IP.
- R3: Every frame starts with seven 0x55 bytes and one 0xD5 byte. These are followed by the destination MAC, the source MAC, the EtherType, then hardware type 0x0001, protocol type 0x0800, hardware size 6 and protocol size 4. After those come the opcode, sender MAC, sender IP, target MAC and target IP. Every multi-byte field is sent most significant byte first.
- R4: The 42 header and body bytes are followed by zero bytes up to 60 frame bytes. `gmii_tx_en` stays high for exactly 72 consecutive cycles per frame. It is low for at least one cycle between frames.
- R5: The last four bytes carry the CRC-32 over the 60 frame bytes, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, an initial value of all ones, and a final inversion.
- R6: A received request (opcode 1) whose target IP equals the local IP produces one reply frame. The reply has opcode 0x0002, and its destination MAC and target MAC both equal the requester's sender MAC. Its target IP equals the requester's sender IP.
- R7: A well-formed request whose target IP differs from the local IP produces no frame.
- R8: A packet is ignored: no frame is sent and `peer_mac` does not change. This applies when hardware type is not 1, protocol type is not 0x0800, hardware size is not 6, protocol size is not 4, or opcode is neither 1 nor 2.
- R9: A well-formed reply (opcode 2) whose target IP equals the local IP loads its sender MAC into `peer_mac` in the cycle after `rx_valid`. It also sets `peer_mac_valid`, which stays set until reset. A later such reply overwrites `peer_mac`. A reply aimed at another IP leaves it unchanged.
- R10: When a reply and a request are both pending, the reply frame is sent first. Work that arrives while a frame is being sent is kept and sent afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_trigger | input | 1 | Ask for a request frame that resolves the peer IP |
| rx_valid | input | 1 | One-cycle strobe: the rx fields below hold a parsed ARP packet |
| rx_htype | input | 16 | Parsed hardware type |
| rx_ptype | input | 16 | Parsed protocol type |
| rx_hlen | input | 8 | Parsed hardware address size |
| rx_plen | input | 8 | Parsed protocol address size |
| rx_oper | input | 16 | Parsed opcode |
| rx_sha | input | 48 | Parsed sender hardware address |
| rx_spa | input | 32 | Parsed sender IP address |
| rx_tpa | input | 32 | Parsed target IP address |
| gmii_txd | output | 8 | Transmit byte |
| gmii_tx_en | output | 1 | Transmit byte valid |
| peer_mac | output | 48 | Resolved peer hardware address |
| peer_mac_valid | output | 1 | A peer address has been resolved |

## Verification
The assertions watch, on every cycle, the shape of the transmit stream: the length of each burst of valid bytes, and that each burst opens with a preamble byte. They also watch the peer address register: it moves only in the cycle after a receive strobe, never after a packet with a wrong hardware type, and its valid flag never drops. Only the bench's scenarios can show the byte contents of each frame, including the padding and the computed check sequence. The same holds for the choice between reply and silence for each kind of received packet, and for the order of two frames queued in the same cycle.

// File: rtl/arp_pkg.sv
package arp_pkg;

    localparam logic [15:0] ETYPE_ARP   = 16'h0806;
    localparam logic [15:0] HW_ETHERNET = 16'h0001;
    localparam logic [15:0] PROTO_IPV4  = 16'h0800;
    localparam logic [7:0]  HW_SIZE     = 8'd6;
    localparam logic [7:0]  PROTO_SIZE  = 8'd4;
    localparam logic [15:0] OP_REQUEST  = 16'd1;
    localparam logic [15:0] OP_REPLY    = 16'd2;
    localparam logic [47:0] MAC_BCAST   = '1;
    localparam int          BODY_BYTES  = 42;
    localparam int          FCS_BYTES   = 4;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;

    typedef enum logic [1:0] {
        RX_IGNORE,
        RX_ASKS_US,
        RX_ANSWERS_US
    } rx_kind_e;

    typedef struct packed {
        logic [47:0] dst;
        logic [15:0] oper;
        logic [47:0] sha;
        logic [31:0] spa;
        logic [47:0] tha;
        logic [31:0] tpa;
    } tx_hdr_t;

    function automatic logic [31:0] crc32_step(logic [31:0] c, logic [7:0] d);
        logic [31:0] r;
        r = c ^ {24'd0, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] fcs_byte(logic [31:0] c, logic [1:0] k);
        logic [31:0] f;
        f = ~c;
        return f[8*k +: 8];
    endfunction

    function automatic logic [7:0] body_byte(tx_hdr_t h, int idx);
        logic [BODY_BYTES*8-1:0] v;
        v = {h.dst, h.sha, ETYPE_ARP, HW_ETHERNET, PROTO_IPV4, HW_SIZE,
             PROTO_SIZE, h.oper, h.sha, h.spa, h.tha, h.tpa};
        if (idx < 0 || idx >= BODY_BYTES) return 8'h00;
        return v[(BODY_BYTES-1-idx)*8 +: 8];
    endfunction

endpackage

// File: rtl/arp_rx_classify.sv
module arp_rx_classify
    import arp_pkg::*;
#(
    parameter logic [31:0] LOCAL_IP = 32'hC0A80001
) (
    input  logic        valid,
    input  logic [15:0] htype,
    input  logic [15:0] ptype,
    input  logic [7:0]  hlen,
    input  logic [7:0]  plen,
    input  logic [15:0] oper,
    input  logic [31:0] tpa,
    output rx_kind_e    kind
);
    logic well_formed;
    logic for_us;

    always_comb begin
        well_formed = valid && htype == HW_ETHERNET && ptype == PROTO_IPV4 &&
                      hlen == HW_SIZE && plen == PROTO_SIZE;
        for_us = well_formed && tpa == LOCAL_IP;
        if (for_us && oper == OP_REQUEST)      kind = RX_ASKS_US;
        else if (for_us && oper == OP_REPLY)   kind = RX_ANSWERS_US;
        else                                   kind = RX_IGNORE;
    end
endmodule

// File: rtl/arp_tx_framer.sv
module arp_tx_framer
    import arp_pkg::*;
#(
    parameter int PRE_LEN = 7,
    parameter int MIN_LEN = 60
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  tx_hdr_t    hdr_in,
    output logic       busy,
    output logic [7:0] txd,
    output logic       tx_en
);
    localparam int SFD_IDX    = PRE_LEN;
    localparam int BODY_START = PRE_LEN + 1;
    localparam int FCS_START  = BODY_START + MIN_LEN;
    localparam int LAST_IDX   = FCS_START + FCS_BYTES - 1;
    localparam int CNT_W      = $clog2(LAST_IDX + 1);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST_IDX);

    logic             busy_q;
    logic [CNT_W-1:0] cnt;
    logic [31:0]      crc;
    tx_hdr_t          hdr_q;
    logic [7:0]       txd_q;
    logic             en_q;
    logic [7:0]       cur;
    logic             in_frame;
    int               pos;

    always_comb begin
        pos      = int'(cnt);
        in_frame = 1'b0;
        if (pos < PRE_LEN) begin
            cur = 8'h55;
        end else if (pos == SFD_IDX) begin
            cur = 8'hD5;
        end else if (pos < FCS_START) begin
            in_frame = 1'b1;
            cur = body_byte(hdr_q, pos - BODY_START);
        end else begin
            cur = fcs_byte(crc, 2'(pos - FCS_START));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt    <= '0;
            crc    <= '1;
            hdr_q  <= '0;
            txd_q  <= '0;
            en_q   <= 1'b0;
        end else if (busy_q) begin
            txd_q <= cur;
            en_q  <= 1'b1;
            if (in_frame) crc <= crc32_step(crc, cur);
            if (cnt == LAST_C) busy_q <= 1'b0;
            else               cnt    <= cnt + 1'b1;
        end else begin
            txd_q <= '0;
            en_q  <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                cnt    <= '0;
                crc    <= '1;
                hdr_q  <= hdr_in;
            end
        end
    end

    assign busy  = busy_q;
    assign txd   = txd_q;
    assign tx_en = en_q;
endmodule

// File: rtl/arp_engine.sv
module arp_engine
    import arp_pkg::*;
#(
    parameter logic [47:0] LOCAL_MAC = 48'h02_00_00_00_00_01,
    parameter logic [31:0] LOCAL_IP  = 32'hC0A80001,
    parameter logic [31:0] PEER_IP   = 32'hC0A80002,
    parameter int          PRE_LEN   = 7,
    parameter int          MIN_LEN   = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_trigger,
    input  logic        rx_valid,
    input  logic [15:0] rx_htype,
    input  logic [15:0] rx_ptype,
    input  logic [7:0]  rx_hlen,
    input  logic [7:0]  rx_plen,
    input  logic [15:0] rx_oper,
    input  logic [47:0] rx_sha,
    input  logic [31:0] rx_spa,
    input  logic [31:0] rx_tpa,
    output logic [7:0]  gmii_txd,
    output logic        gmii_tx_en,
    output logic [47:0] peer_mac,
    output logic        peer_mac_valid
);
    rx_kind_e    kind;
    logic        req_pend, rep_pend;
    logic [47:0] rep_mac;
    logic [31:0] rep_ip;
    logic        busy, start;
    tx_hdr_t     hdr;

    arp_rx_classify #(.LOCAL_IP(LOCAL_IP)) u_cls (
        .valid(rx_valid), .htype(rx_htype), .ptype(rx_ptype), .hlen(rx_hlen),
        .plen(rx_plen), .oper(rx_oper), .tpa(rx_tpa), .kind(kind)
    );

    assign start = !busy && (rep_pend || req_pend);

    always_comb begin
        hdr.sha = LOCAL_MAC;
        hdr.spa = LOCAL_IP;
        if (rep_pend) begin
            hdr.dst  = rep_mac;
            hdr.oper = OP_REPLY;
            hdr.tha  = rep_mac;
            hdr.tpa  = rep_ip;
        end else begin
            hdr.dst  = MAC_BCAST;
            hdr.oper = OP_REQUEST;
            hdr.tha  = '0;
            hdr.tpa  = PEER_IP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_pend       <= 1'b0;
            rep_pend       <= 1'b0;
            rep_mac        <= '0;
            rep_ip         <= '0;
            peer_mac       <= '0;
            peer_mac_valid <= 1'b0;
        end else begin
            if (req_trigger)                req_pend <= 1'b1;
            else if (start && !rep_pend)    req_pend <= 1'b0;

            if (kind == RX_ASKS_US) begin
                rep_pend <= 1'b1;
                rep_mac  <= rx_sha;
                rep_ip   <= rx_spa;
            end else if (start && rep_pend) begin
                rep_pend <= 1'b0;
            end

            if (kind == RX_ANSWERS_US) begin
                peer_mac       <= rx_sha;
                peer_mac_valid <= 1'b1;
            end
        end
    end

    arp_tx_framer #(.PRE_LEN(PRE_LEN), .MIN_LEN(MIN_LEN)) u_tx (
        .clk(clk), .rst(rst), .start(start), .hdr_in(hdr),
        .busy(busy), .txd(gmii_txd), .tx_en(gmii_tx_en)
    );
endmodule

// File: rtl/arp_engine_chk.sv
module arp_engine_chk #(
    parameter int FRAME_BYTES = 72
) (
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic [15:0] rx_htype,
    input logic [7:0]  gmii_txd,
    input logic        gmii_tx_en,
    input logic [47:0] peer_mac,
    input logic        peer_mac_valid
);
    int run;

    always_ff @(posedge clk) begin
        if (rst)             run <= 0;
        else if (gmii_tx_en) run <= (run < FRAME_BYTES + 1) ? run + 1 : run;
        else                 run <= 0;
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run <= FRAME_BYTES); // R4
    AST_RUN_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(gmii_tx_en) |-> run == FRAME_BYTES); // R4
    AST_PREAMBLE_OPEN: assert property (@(posedge clk) disable iff (rst)
        $rose(gmii_tx_en) |-> gmii_txd == 8'h55); // R3
    AST_PEER_STICKY: assert property (@(posedge clk) disable iff (rst)
        $past(peer_mac_valid) |-> peer_mac_valid); // R9
    AST_PEER_ONLY_ON_RX: assert property (@(posedge clk) disable iff (rst)
        !$past(rx_valid) |-> $stable(peer_mac)); // R9
    AST_BAD_HTYPE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        $past(rx_valid && rx_htype != 16'h0001) |-> $stable(peer_mac)); // R8
endmodule

bind arp_engine arp_engine_chk u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_htype(rx_htype),
    .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en),
    .peer_mac(peer_mac), .peer_mac_valid(peer_mac_valid)
);

// File: tb/tb_arp_engine.sv
`timescale 1ns/1ps
module tb_arp_engine;
    localparam logic [47:0] LMAC = 48'h02_00_00_00_00_01;
    localparam logic [31:0] LIP  = 32'hC0A80001;
    localparam logic [31:0] PIP  = 32'hC0A80002;

    logic clk = 0, rst = 1, req_trigger = 0, rx_valid = 0;
    logic [15:0] rx_htype = 0, rx_ptype = 0, rx_oper = 0;
    logic [7:0]  rx_hlen = 0, rx_plen = 0;
    logic [47:0] rx_sha = 0;
    logic [31:0] rx_spa = 0, rx_tpa = 0;
    logic [7:0]  gmii_txd;
    logic        gmii_tx_en, peer_mac_valid;
    logic [47:0] peer_mac;

    always #4 clk = ~clk;

    arp_engine dut (
        .clk(clk), .rst(rst), .req_trigger(req_trigger), .rx_valid(rx_valid),
        .rx_htype(rx_htype), .rx_ptype(rx_ptype), .rx_hlen(rx_hlen), .rx_plen(rx_plen),
        .rx_oper(rx_oper), .rx_sha(rx_sha), .rx_spa(rx_spa), .rx_tpa(rx_tpa),
        .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en),
        .peer_mac(peer_mac), .peer_mac_valid(peer_mac_valid)
    );

    int checks = 0, errors = 0;
    logic [7:0] cap [0:159];
    int cap_len = 0, frames = 0;
    logic prev_en = 0;
    logic [7:0] exp_b [0:71];
    int wp;

    always @(negedge clk) begin
        if (gmii_tx_en) begin
            if (cap_len < 160) cap[cap_len] = gmii_txd;
            cap_len++;
        end
        if (prev_en && !gmii_tx_en) frames++;
        prev_en = gmii_tx_en;
    end

    task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic put(logic [47:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            exp_b[wp] = v[8*i +: 8];
            wp++;
        end
    endtask

    task automatic build(logic [47:0] dst, logic [15:0] op, logic [47:0] tha, logic [31:0] tpa);
        logic [31:0] c;
        for (int i = 0; i < 7; i++) exp_b[i] = 8'h55;
        exp_b[7] = 8'hD5;
        wp = 8;
        put(dst, 6); put(LMAC, 6); put(48'h0806, 2); put(48'h0001, 2);
        put(48'h0800, 2); put(48'h06, 1); put(48'h04, 1); put({32'd0, op}, 2);
        put(LMAC, 6); put({16'd0, LIP}, 4); put(tha, 6); put({16'd0, tpa}, 4);
        while (wp < 68) begin exp_b[wp] = 8'h00; wp++; end
        c = 32'hFFFFFFFF;
        for (int i = 8; i < 68; i++)
            for (int b = 0; b < 8; b++) begin
                logic fb;
                fb = c[0] ^ exp_b[i][b];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB88320;
            end
        c = ~c;
        for (int k = 0; k < 4; k++) exp_b[68 + k] = c[8*k +: 8];
    endtask

    task automatic cmp_range(string tag, int base, int lo, int hi);
        int bad;
        bad = -1;
        for (int i = lo; i <= hi; i++)
            if (bad < 0 && cap[base + i] !== exp_b[i]) bad = i;
        checks++;
        if (bad >= 0) begin
            errors++;
            $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, bad, cap[base + bad], exp_b[bad]);
        end
    endtask

    task automatic clear_cap();
        cap_len = 0;
        frames = 0;
    endtask

    task automatic send_rx(logic [15:0] ht, logic [15:0] pt, logic [7:0] hl, logic [7:0] pl,
                           logic [15:0] op, logic [47:0] sha, logic [31:0] spa, logic [31:0] tpa);
        rx_valid = 1; rx_htype = ht; rx_ptype = pt; rx_hlen = hl; rx_plen = pl;
        rx_oper = op; rx_sha = sha; rx_spa = spa; rx_tpa = tpa;
    endtask

    typedef struct packed {
        logic [15:0] ht; logic [15:0] pt; logic [7:0] hl; logic [7:0] pl;
        logic [15:0] op; logic [47:0] sha; logic [31:0] spa; logic [31:0] tpa;
        logic rep; logic latch;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [0:NV-1] = '{
        '{16'h0001, 16'h0800, 8'd6, 8'd4, 16'd1, 48'h02AABBCCDDEE, 32'hC0A80005, LIP,          1'b1, 1'b0},
        '{16'h0001, 16'h0800, 8'd6, 8'd4, 16'd1, 48'h02AABBCCDDEE, 32'hC0A80005, 32'hC0A80009, 1'b0, 1'b0},
        '{16'h0002, 16'h0800, 8'd6, 8'd4, 16'd1, 48'h02AABBCCDDEE, 32'hC0A80005, LIP,          1'b0, 1'b0},
        '{16'h0001, 16'h0800, 8'd6, 8'd6, 16'd1, 48'h02AABBCCDDEE, 32'hC0A80005, LIP,          1'b0, 1'b0},
        '{16'h0001, 16'h0800, 8'd6, 8'd4, 16'd3, 48'h02AABBCCDDEE, 32'hC0A80005, LIP,          1'b0, 1'b0},
        '{16'h0001, 16'h0800, 8'd6, 8'd4, 16'd2, 48'h021122334455, PIP,          LIP,          1'b0, 1'b1},
        '{16'h0001, 16'h86DD, 8'd6, 8'd4, 16'd2, 48'h02DEADBEEF01, PIP,          LIP,          1'b0, 1'b0},
        '{16'h0001, 16'h0800, 8'd4, 8'd4, 16'd2, 48'h02DEADBEEF02, PIP,          LIP,          1'b0, 1'b0},
        '{16'h0001, 16'h0800, 8'd6, 8'd4, 16'd2, 48'h0266778899AA, PIP,          LIP,          1'b0, 1'b1},
        '{16'h0001, 16'h0800, 8'd6, 8'd4, 16'd2, 48'h02CAFECAFE00, PIP,          32'hC0A80077, 1'b0, 1'b0}
    };

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] exp_peer;
        logic        exp_pv;
        exp_peer = '0;
        exp_pv = 0;
        repeat (4) @(posedge clk);
        #1;
        check("R1 tx_en in reset", {63'd0, gmii_tx_en}, 64'd0);
        rst = 0;
        @(posedge clk); #1;
        check("R1 tx_en after reset", {63'd0, gmii_tx_en}, 64'd0);
        check("R1 peer valid", {63'd0, peer_mac_valid}, 64'd0);
        check("R1 peer mac", {16'd0, peer_mac}, 64'd0);

        // Request frame: R2 R3 R4 R5
        clear_cap();
        req_trigger = 1;
        @(posedge clk); #1 req_trigger = 0;
        repeat (90) @(posedge clk);
        #1;
        build(48'hFFFFFFFFFFFF, 16'd1, 48'd0, PIP);
        check("R4 one frame", frames, 1);
        check("R4 length 72", cap_len, 72);
        cmp_range("R3 preamble", 0, 0, 7);
        cmp_range("R2 broadcast dst", 0, 8, 13);
        cmp_range("R2 opcode", 0, 28, 29);
        cmp_range("R2 target fields", 0, 40, 49);
        cmp_range("R3 whole header", 0, 0, 49);
        cmp_range("R4 zero padding", 0, 50, 67);
        cmp_range("R5 fcs", 0, 68, 71);

        // Table of received packets: R6 R7 R8 R9
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = VEC[v].rep ? "R6" : (VEC[v].latch ? "R9" :
                  ((VEC[v].op == 16'd2 && VEC[v].tpa != LIP) ? "R9 other ip" :
                  ((VEC[v].ht == 16'h0001 && VEC[v].pt == 16'h0800 && VEC[v].hl == 8'd6 &&
                    VEC[v].pl == 8'd4 && VEC[v].op == 16'd1) ? "R7" : "R8")));
            clear_cap();
            send_rx(VEC[v].ht, VEC[v].pt, VEC[v].hl, VEC[v].pl, VEC[v].op,
                    VEC[v].sha, VEC[v].spa, VEC[v].tpa);
            @(posedge clk); #1 rx_valid = 0;
            if (VEC[v].latch) begin
                exp_peer = VEC[v].sha;
                exp_pv = 1;
            end
            check({tag, " peer mac next cycle"}, {16'd0, peer_mac}, {16'd0, exp_peer});
            repeat (90) @(posedge clk);
            #1;
            check({tag, " frame count"}, frames, VEC[v].rep ? 1 : 0);
            if (VEC[v].rep) begin
                build(VEC[v].sha, 16'd2, VEC[v].sha, VEC[v].spa);
                cmp_range({tag, " reply frame"}, 0, 0, 71);
            end
            check({tag, " peer mac"}, {16'd0, peer_mac}, {16'd0, exp_peer});
            check({tag, " peer valid"}, {63'd0, peer_mac_valid}, {63'd0, exp_pv});
        end

        // Both pending in the same cycle: reply first, request after (R10)
        clear_cap();
        req_trigger = 1;
        send_rx(16'h0001, 16'h0800, 8'd6, 8'd4, 16'd1, 48'h02ABCDEF0123, 32'hC0A80033, LIP);
        @(posedge clk); #1;
        req_trigger = 0;
        rx_valid = 0;
        repeat (180) @(posedge clk);
        #1;
        check("R10 two frames", frames, 2);
        check("R10 bytes", cap_len, 144);
        build(48'h02ABCDEF0123, 16'd2, 48'h02ABCDEF0123, 32'hC0A80033);
        cmp_range("R10 first is reply", 0, 0, 71);
        build(48'hFFFFFFFFFFFF, 16'd1, 48'd0, PIP);
        cmp_range("R10 second is request", 72, 0, 71);

        // Request arriving mid-frame is kept (R10)
        clear_cap();
        req_trigger = 1;
        @(posedge clk); #1 req_trigger = 0;
        repeat (20) @(posedge clk);
        #1 req_trigger = 1;
        @(posedge clk); #1 req_trigger = 0;
        repeat (160) @(posedge clk);
        #1;
        check("R10 queued during frame", frames, 2);
        cmp_range("R10 queued request content", 72, 0, 71);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule